// File: doc/BRIEF.md
# Channel Address to System Address Denormalizer

This block rebuilds a system physical address from an address that has been normalized to one memory channel. Each request carries a 64-bit channel-local address. A set of static configuration words comes with it: two base/limit pairs, an optional high-address offset, the fabric identifier of the channel, a word holding the die and socket identifier masks and shifts, and the start of the legacy MMIO hole. The block puts the interleave identifier bits back in at a programmable bit position and adds the DRAM base. It then jumps the address over the MMIO hole and can apply an XOR-hash correction to the interleave start bit. The result is range-checked against the limit.

Requests enter and results leave on valid/ready streams through a three-stage pipeline. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. The whole pipeline stalls while a result is waiting and `out_ready` is low. During that time `in_ready` is low and the output holds steady. The configuration words must stay stable while requests are in flight. A request that fails any configuration or range check comes out with `out_err` set instead of an address.

Top module: `dram_addr_denorm`

## Requirements
- R1: Results leave in request order. With `out_ready` held high, a request accepted at one clock edge shows `out_valid` after the third edge counting that one. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_addr`/`out_err` hold their values.
- R2: After reset, `out_valid` is low and `in_ready` is high.
- R3: Bit 0 of `cfg_hi_offset` enables the high offset. The offset value is `cfg_hi_offset[31:20]` placed at address bits [39:28]. When the offset is enabled and the input address is at least the offset, the offset is subtracted and pair 1 (`cfg_base1`/`cfg_limit1`) is used. Otherwise the address passes unchanged and pair 0 is used.
- R4: In the selected base word, bit 0 marks the range valid, and a clear bit gives an error. Bit 1 enables the MMIO hole. Bits [7:4] are the channel code and bits [10:8] are the start select. The DRAM base is word[31:12] placed at address bits [47:28], and it is added to the spliced address.
- R5: Start select values 0 to 3 place the interleave start at address bit 8 to 11. A value above 3 gives an error.
- R6: The channel code gives the number of channel bits: 0→0, 1→1, 3→2, 5→3, 7→4. Code 8 gives 1 bit with hashing on. Every other code gives an error.
- R7: In the selected limit word, bit 8 is the socket bit count and bits [11:10] are the die bit count. A die count above 2 gives an error. The limit is word[31:12] at bits [47:28] with bits [27:0] all ones. A channel+die+socket total above 4 gives an error.
- R8: With start S and total T, the spliced address is (address bits at and above S shifted up by T) OR (ID << S) OR (address bits below S). The ID has the following fields:
  - The channel field is `cfg_fabric_id` masked to the channel bits.
  - Above it sits ((fabric & die mask) >> die shift). `cfg_sys_mask` holds the die mask in bits [15:8] and the die shift in bits [27:24].
  - Above that sits ((fabric & socket mask) >> socket shift). The socket mask is in bits [23:16] and the socket shift in bits [31:28].
  - The ID is truncated to T bits.
- R9: When the hole is enabled and the address after base addition is at or above `cfg_hole[31:24]` placed at bits [31:24], the value 2^32 minus the hole base is added.
- R10: When hashing is on, let h be the XOR of bits 12, 18, 21 and 30 of the address after the hole step. If h differs from the bit at the interleave start, that bit is flipped.
- R11: A final address greater than the limit gives an error. An address equal to the limit does not.
- R12: An errored result has `out_err` high and `out_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request may be accepted |
| in_naddr | input | 64 | Channel-normalized address |
| cfg_hi_offset | input | 32 | High offset enable (bit 0) and value (bits 31:20) |
| cfg_base0 | input | 32 | Base word, pair 0 |
| cfg_limit0 | input | 32 | Limit word, pair 0 |
| cfg_base1 | input | 32 | Base word, pair 1 |
| cfg_limit1 | input | 32 | Limit word, pair 1 |
| cfg_sys_mask | input | 32 | Die/socket identifier masks and shifts |
| cfg_hole | input | 32 | MMIO hole base in bits 31:24 |
| cfg_fabric_id | input | 8 | Fabric identifier of the channel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result may be taken |
| out_addr | output | 64 | System address (zero on error) |
| out_err | output | 1 | Configuration or range error |

## Verification
The bench aims at the splice itself with every field present at the highest start bit. A wrong shift would scatter identifier bits or lose upper address bits. It tests addresses on both sides of the hole base and of the high offset, where an off-by-one compare would skip the hole or pick the wrong base/limit pair. It covers each illegal channel code, start select, die count and total width, and an address exactly at the limit. It also drives a hashed address whose start bit must flip next to an unhashed one that must not, and it holds the output stream back to check that nothing is lost or reordered under stall.

// File: rtl/dnorm_pkg.sv
package dnorm_pkg;
  localparam int AW       = 64;  // address width
  localparam int CW       = 32;  // configuration word width
  localparam int FW       = 8;   // fabric identifier width
  localparam int MAXB     = 4;   // most interleave bits allowed
  localparam int IDW      = MAXB;
  localparam int NBW      = $clog2(MAXB + 1);
  localparam int SW       = 4;   // start position width
  localparam int START0   = 8;   // lowest interleave start bit
  localparam int BASE_LSB = 28;  // base/limit/offset field placement
  localparam int HOLE_LSB = 24;
  localparam int HOLE_W   = 8;
  localparam int OFF_W    = 12;
  localparam int RNG_W    = 20;

  typedef struct packed {
    logic [AW-1:0]     addr;
    logic [AW-1:0]     base;
    logic [AW-1:0]     limit;
    logic [IDW-1:0]    id;
    logic [SW-1:0]     start;
    logic [NBW-1:0]    nbits;
    logic              hole_en;
    logic [HOLE_W-1:0] hole_top;
    logic              hash_en;
    logic              err;
  } dec_t;

  typedef struct packed {
    logic [AW-1:0]     addr;
    logic [AW-1:0]     limit;
    logic [SW-1:0]     start;
    logic              hole_en;
    logic [HOLE_W-1:0] hole_top;
    logic              hash_en;
    logic              err;
  } spl_t;
endpackage

// File: rtl/dnorm_decode.sv
module dnorm_decode
  import dnorm_pkg::*;
(
  input  logic [AW-1:0] naddr,
  input  logic [CW-1:0] hi_off_w,
  input  logic [CW-1:0] base0_w,
  input  logic [CW-1:0] limit0_w,
  input  logic [CW-1:0] base1_w,
  input  logic [CW-1:0] limit1_w,
  input  logic [CW-1:0] sys_mask_w,
  input  logic [CW-1:0] hole_w,
  input  logic [FW-1:0] fabric_id,
  output dec_t          dec
);
  logic [AW-1:0] hi_off;
  logic          use_hi;
  logic [CW-1:0] bw, lw;
  logic [2:0]    sel;
  logic [2:0]    ch_bits;
  logic          bad_code, hash_on;
  logic [1:0]    die_bits;
  logic          sock_bit;
  logic [3:0]    total;
  logic [FW-1:0] ch_mask, die_f, sock_f, id_full;
  logic [IDW-1:0] id_mask;
  logic          unused_bits;

  assign unused_bits = ^{hi_off_w[19:1], bw[3:2], bw[11], lw[9], lw[7:0],
                         sys_mask_w[7:0], hole_w[23:0], id_full[FW-1:IDW]};

  always_comb begin
    hi_off = '0;
    hi_off[BASE_LSB +: OFF_W] = hi_off_w[CW-1 -: OFF_W];
    use_hi = hi_off_w[0] && (naddr >= hi_off);
    bw     = use_hi ? base1_w  : base0_w;
    lw     = use_hi ? limit1_w : limit0_w;
    sel    = bw[10:8];

    bad_code = 1'b0;
    hash_on  = 1'b0;
    case (bw[7:4])
      4'd0: ch_bits = 3'd0;
      4'd1: ch_bits = 3'd1;
      4'd3: ch_bits = 3'd2;
      4'd5: ch_bits = 3'd3;
      4'd7: ch_bits = 3'd4;
      4'd8: begin ch_bits = 3'd1; hash_on = 1'b1; end
      default: begin ch_bits = 3'd0; bad_code = 1'b1; end
    endcase

    die_bits = lw[11:10];
    sock_bit = lw[8];
    total    = {1'b0, ch_bits} + {2'b0, die_bits} + {3'b0, sock_bit};

    ch_mask = ~({FW{1'b1}} << ch_bits);
    die_f   = (fabric_id & sys_mask_w[15:8])  >> sys_mask_w[27:24];
    sock_f  = (fabric_id & sys_mask_w[23:16]) >> sys_mask_w[31:28];
    id_full = fabric_id & ch_mask;
    if (die_bits != 2'd0) id_full = id_full | (die_f << ch_bits);
    if (sock_bit)         id_full = id_full | (sock_f << (ch_bits + {1'b0, die_bits}));
    id_mask = ~({IDW{1'b1}} << total);

    dec.addr     = use_hi ? (naddr - hi_off) : naddr;
    dec.base     = '0;
    dec.base[BASE_LSB +: RNG_W] = bw[CW-1 -: RNG_W];
    dec.limit    = '0;
    dec.limit[BASE_LSB +: RNG_W] = lw[CW-1 -: RNG_W];
    dec.limit[BASE_LSB-1:0] = '1;
    dec.id       = id_full[IDW-1:0] & id_mask;
    dec.start    = SW'(START0) + {2'b0, sel[1:0]};
    dec.nbits    = total[NBW-1:0];
    dec.hole_en  = bw[1];
    dec.hole_top = hole_w[CW-1 -: HOLE_W];
    dec.hash_en  = hash_on;
    dec.err      = !bw[0] || (sel > 3'd3) || bad_code ||
                   (die_bits > 2'd2) || (total > 4'(MAXB));
  end
endmodule

// File: rtl/dnorm_splice.sv
module dnorm_splice
  import dnorm_pkg::*;
(
  input  dec_t d,
  output spl_t s
);
  logic [AW-1:0] lo_mask, low_part, high_part, id_part;

  always_comb begin
    lo_mask   = ~({AW{1'b1}} << d.start);
    low_part  = d.addr & lo_mask;
    high_part = (d.addr & ~lo_mask) << d.nbits;
    id_part   = AW'(d.id) << d.start;
    s.addr     = (high_part | id_part | low_part) + d.base;
    s.limit    = d.limit;
    s.start    = d.start;
    s.hole_en  = d.hole_en;
    s.hole_top = d.hole_top;
    s.hash_en  = d.hash_en;
    s.err      = d.err;
  end
endmodule

// File: rtl/dnorm_fixup.sv
module dnorm_fixup
  import dnorm_pkg::*;
(
  input  spl_t          s,
  output logic [AW-1:0] addr,
  output logic          err
);
  logic [AW-1:0] hole_base, after_hole, after_hash;
  logic          hbit;

  always_comb begin
    hole_base = '0;
    hole_base[HOLE_LSB +: HOLE_W] = s.hole_top;
    after_hole = (s.hole_en && s.addr >= hole_base)
               ? s.addr + ((AW'(1) << 32) - hole_base) : s.addr;
    hbit = after_hole[12] ^ after_hole[18] ^ after_hole[21] ^ after_hole[30];
    after_hash = (s.hash_en && (hbit != after_hole[s.start]))
               ? after_hole ^ (AW'(1) << s.start) : after_hole;
    err  = s.err || (after_hash > s.limit);
    addr = err ? '0 : after_hash;
  end
endmodule

// File: rtl/dram_addr_denorm.sv
module dram_addr_denorm
  import dnorm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_naddr,
  input  logic [CW-1:0] cfg_hi_offset,
  input  logic [CW-1:0] cfg_base0,
  input  logic [CW-1:0] cfg_limit0,
  input  logic [CW-1:0] cfg_base1,
  input  logic [CW-1:0] cfg_limit1,
  input  logic [CW-1:0] cfg_sys_mask,
  input  logic [CW-1:0] cfg_hole,
  input  logic [FW-1:0] cfg_fabric_id,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_err
);
  dec_t          dec_c, s1_q;
  spl_t          spl_c, s2_q;
  logic          s1_v, s2_v;
  logic [AW-1:0] fix_addr;
  logic          fix_err;
  logic          advance;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  dnorm_decode u_decode (
    .naddr(in_naddr), .hi_off_w(cfg_hi_offset),
    .base0_w(cfg_base0), .limit0_w(cfg_limit0),
    .base1_w(cfg_base1), .limit1_w(cfg_limit1),
    .sys_mask_w(cfg_sys_mask), .hole_w(cfg_hole),
    .fabric_id(cfg_fabric_id), .dec(dec_c)
  );

  dnorm_splice u_splice (.d(s1_q), .s(spl_c));

  dnorm_fixup u_fixup (.s(s2_q), .addr(fix_addr), .err(fix_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
      s1_q      <= '0;
      s2_q      <= '0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else if (advance) begin
      s1_v      <= in_valid;
      s1_q      <= dec_c;
      s2_v      <= s1_v;
      s2_q      <= spl_c;
      out_valid <= s2_v;
      out_addr  <= fix_addr;
      out_err   <= fix_err;
    end
  end
endmodule

// File: rtl/dnorm_checker.sv
module dnorm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_addr,
  input logic        out_err
);
  logic [2:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!out_valid); // R2
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_err)); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3); // R1
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 3'd0); // R1
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_addr == 64'd0); // R12
endmodule

bind dram_addr_denorm dnorm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_err(out_err)
);

// File: tb/dram_addr_denorm_bench.sv
module dram_addr_denorm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_naddr = '0;
  logic [31:0] cfg_hi_offset = '0, cfg_base0 = '0, cfg_limit0 = '0;
  logic [31:0] cfg_base1 = '0, cfg_limit1 = '0, cfg_sys_mask = '0, cfg_hole = '0;
  logic [7:0]  cfg_fabric_id = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;
  logic        out_err;
  int          n_checks = 0;
  int          n_fail = 0;
  int          cycles = 0;

  always #2 clk = ~clk;

  dram_addr_denorm u_dram_addr_denorm (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result from the requirements: {err, addr}
  function automatic logic [64:0] model(input logic [63:0] na);
    logic [63:0] off, a, r, hb, lim, base, idv;
    logic [31:0] bw, lw;
    bit err, hash, sel;
    int ch, die, sk, tot, st;
    off = {24'b0, cfg_hi_offset[31:20], 28'b0};
    sel = cfg_hi_offset[0] && na >= off;
    a  = sel ? na - off : na;
    bw = sel ? cfg_base1 : cfg_base0;
    lw = sel ? cfg_limit1 : cfg_limit0;
    err = !bw[0]; hash = 0;
    if (bw[10:8] > 3) err = 1;
    case (bw[7:4])
      0: ch = 0; 1: ch = 1; 3: ch = 2; 5: ch = 3; 7: ch = 4;
      8: begin ch = 1; hash = 1; end
      default: begin ch = 0; err = 1; end
    endcase
    die = int'(lw[11:10]); sk = int'(lw[8]);
    if (die > 2) err = 1;
    tot = ch + die + sk;
    if (tot > 4) err = 1;
    idv = 64'(cfg_fabric_id) & ((64'd1 << ch) - 1);
    if (die != 0) idv |= ((64'(cfg_fabric_id) & 64'(cfg_sys_mask[15:8])) >> cfg_sys_mask[27:24]) << ch;
    if (sk != 0)  idv |= ((64'(cfg_fabric_id) & 64'(cfg_sys_mask[23:16])) >> cfg_sys_mask[31:28]) << (ch + die);
    idv &= (64'd1 << tot) - 1;
    st = 8 + int'(bw[9:8]);
    base = 64'(bw[31:12]) << 28;
    lim  = (64'(lw[31:12]) << 28) | 64'h0FFF_FFFF;
    r = ((a >> st) << (st + tot)) | (idv << st) | (a & ((64'd1 << st) - 1));
    r = r + base;
    hb = 64'(cfg_hole[31:24]) << 24;
    if (bw[1] && r >= hb) r = r + (64'h1_0000_0000 - hb);
    if (hash && ((r[12] ^ r[18] ^ r[21] ^ r[30]) != r[st])) r[st] = ~r[st];
    if (r > lim) err = 1;
    return {err, err ? 64'd0 : r};
  endfunction

  task automatic send_wait(input logic [63:0] na, output logic [64:0] res);
    int guard;
    @(negedge clk);
    in_valid = 1'b1; in_naddr = na;
    @(negedge clk);
    in_valid = 1'b0;
    guard = 0;
    while (!out_valid && guard < 20) begin @(negedge clk); guard++; end
    res = {out_err, out_addr};
  endtask

  task automatic run(input logic [63:0] na, input string tag);
    logic [64:0] res, exp;
    exp = model(na);
    send_wait(na, res);
    check(res === exp, tag, res, exp);
  endtask

  task automatic run_hand(input logic [63:0] na, input logic [64:0] exp, input string tag);
    logic [64:0] res;
    send_wait(na, res);
    check(res === exp, tag, res, exp);
  endtask

  task automatic cfg_plain;
    cfg_hi_offset = '0; cfg_base0 = 32'h0000_0001; cfg_limit0 = 32'hFFFF_F000;
    cfg_base1 = 32'h0000_0001; cfg_limit1 = 32'hFFFF_F000;
    cfg_sys_mask = '0; cfg_hole = '0; cfg_fabric_id = '0;
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0, "R2 out_valid after reset", 65'(out_valid), 65'd0);
    check(in_ready === 1'b1, "R2 in_ready after reset", 65'(in_ready), 65'd1);
  endtask

  task automatic t_latency;
    int seen;
    cfg_plain();
    @(negedge clk); in_valid = 1'b1; in_naddr = 64'h55;
    @(negedge clk); in_valid = 1'b0;   // accept edge passed
    seen = 0;
    for (int k = 0; k < 2; k++) begin
      if (out_valid) seen = 1;
      @(negedge clk);
    end
    check(seen == 0 && out_valid === 1'b1, "R1 three-edge latency", 65'(out_valid), 65'd1);
    @(negedge clk);
  endtask

  task automatic t_base_two_way;
    cfg_plain();
    cfg_base0 = 32'h0000_1011;  // base field 1 -> 0x1000_0000, code 1, start 8
    cfg_fabric_id = 8'h01;
    run_hand(64'h1234, {1'b0, 64'h1000_2534}, "R4 R8 two-way splice plus base");
    cfg_fabric_id = 8'h00;
    run_hand(64'h1234, {1'b0, 64'h1000_2434}, "R8 channel id zero");
  endtask

  task automatic t_full_id;
    cfg_plain();
    cfg_base0 = 32'h0000_0331; cfg_limit0 = 32'hFFFF_F500;
    cfg_sys_mask = 32'h7480_1000; cfg_fabric_id = 8'hB6;
    run_hand(64'h12345, {1'b0, 64'h0012_7345}, "R5 R8 channel+die+socket at bit 11");
    cfg_base0 = 32'h0000_0271; cfg_limit0 = 32'hFFFF_F000;
    run(64'hDEAD_BEEF_0123, "R6 R8 sixteen channels at bit 10");
    cfg_base0 = 32'h0000_0151; cfg_limit0 = 32'hFFFF_F800;
    run(64'h0ABC_DEF0, "R7 eight channels with two die bits");
  endtask

  task automatic t_errors;
    cfg_plain(); cfg_base0 = 32'h0000_0000;
    run_hand(64'h100, {1'b1, 64'd0}, "R4 R12 range invalid");
    cfg_base0 = 32'h0000_0401;
    run_hand(64'h100, {1'b1, 64'd0}, "R5 start select 4");
    cfg_base0 = 32'h0000_0301;
    run_hand(64'h100, {1'b0, 64'h100}, "R5 start select 3 legal");
    cfg_base0 = 32'h0000_0021;
    run_hand(64'h100, {1'b1, 64'd0}, "R6 channel code 2");
    cfg_base0 = 32'h0000_0091;
    run_hand(64'h100, {1'b1, 64'd0}, "R6 channel code 9");
    cfg_base0 = 32'h0000_0001; cfg_limit0 = 32'hFFFF_FC00;
    run_hand(64'h100, {1'b1, 64'd0}, "R7 die count 3");
    cfg_base0 = 32'h0000_0071; cfg_limit0 = 32'hFFFF_F100;
    run_hand(64'h100, {1'b1, 64'd0}, "R7 total five bits");
    cfg_base0 = 32'h0000_0071; cfg_limit0 = 32'hFFFF_F000;
    run(64'h100, "R7 total four bits legal");
  endtask

  task automatic t_limit;
    cfg_plain(); cfg_limit0 = 32'h0000_0000;
    run_hand(64'h0FFF_FFFF, {1'b0, 64'h0FFF_FFFF}, "R11 at limit");
    run_hand(64'h1000_0000, {1'b1, 64'd0}, "R11 above limit");
  endtask

  task automatic t_hi_offset;
    cfg_plain();
    cfg_hi_offset = 32'h0010_0001;       // offset 0x1000_0000
    cfg_base1 = 32'h0000_2001;           // base 0x2000_0000
    run_hand(64'h1000_0040, {1'b0, 64'h2000_0040}, "R3 offset subtracted, pair 1");
    run_hand(64'h0FFF_FFFF, {1'b0, 64'h0FFF_FFFF}, "R3 below offset, pair 0");
    cfg_hi_offset = 32'h0010_0000;
    run_hand(64'h1000_0040, {1'b0, 64'h1000_0040}, "R3 offset disabled");
  endtask

  task automatic t_hole;
    cfg_plain(); cfg_base0 = 32'h0000_0003; cfg_hole = 32'hC000_0000;
    run_hand(64'hC000_0010, {1'b0, 64'h1_0000_0010}, "R9 at hole skipped");
    run_hand(64'hBFFF_FFFF, {1'b0, 64'hBFFF_FFFF}, "R9 below hole unchanged");
    cfg_base0 = 32'h0000_0001;
    run_hand(64'hC000_0010, {1'b0, 64'hC000_0010}, "R9 hole disabled");
  endtask

  task automatic t_hash;
    cfg_plain(); cfg_base0 = 32'h0000_0081;
    run_hand(64'h800, {1'b0, 64'h1100}, "R10 hash flips start bit");
    run_hand(64'h1000, {1'b0, 64'h2000}, "R10 hash no flip");
    cfg_base0 = 32'h0000_0011;
    run_hand(64'h800, {1'b0, 64'h1000}, "R10 no hash on code 1");
  endtask

  task automatic t_backpressure;
    logic [63:0] v [3];
    int acc;
    bit rdy;
    cfg_plain(); cfg_base0 = 32'h0000_1001;
    v[0] = 64'h10; v[1] = 64'h20; v[2] = 64'h30;
    @(negedge clk); out_ready = 1'b0;
    acc = 0;
    while (acc < 3) begin
      in_valid = 1'b1; in_naddr = v[acc];
      rdy = in_ready;
      @(negedge clk);
      if (rdy) acc++;
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(in_ready === 1'b0, "R1 in_ready low under stall", 65'(in_ready), 65'd0);
    check({out_err, out_addr} === model(v[0]), "R1 first result held", {out_err, out_addr}, model(v[0]));
    out_ready = 1'b1;
    for (int j = 0; j < 3; j++) begin
      check(out_valid === 1'b1 && {out_err, out_addr} === model(v[j]), "R1 order after release",
            {out_err, out_addr}, model(v[j]));
      @(negedge clk);
    end
    check(out_valid === 1'b0, "R1 drained", 65'(out_valid), 65'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_latency();
    t_base_two_way();
    t_full_id();
    t_errors();
    t_limit();
    t_hi_offset();
    t_hole();
    t_hash();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule